// File: doc/BRIEF.md
# Humidity Sensor I2C Target Front End

This block is the bus-facing side of a measurement device sitting on an open-drain I2C bus. A controller writes one command byte to the target's 7-bit address to start a conversion. The block then sends a one-cycle start pulse to the measurement engine. It waits for the engine's done strobe, captures the 16-bit result, and returns it as two bytes, most significant byte first, when the controller reads from the target's address.

Two commands pick how readiness is signalled. With the holding command, the target acknowledges the read address and then keeps SCL low for as long as the conversion takes. Before letting SCL go, it puts the first result bit on SDA. With the polling command, the controller may end the write with a STOP and use the bus for other devices. Any read address sent before the result is ready is refused with a NACK. Once the result is ready, the read address is acknowledged. The result stays pending until it has been read out in full. A START or STOP that interrupts a transfer does not discard it.

SCL and SDA enter through a synchronizer. Each line has a separate sampled input and an active-high pull-low output, which the pad drives as open drain.

Top module: `i2c_meas_target`

## Requirements
- R1: After reset, the target pulls neither SCL nor SDA low and does not pulse the conversion start.
- R2: A write to the target's own 7-bit address (parameter, default 0x40; R/W bit 0 means write) is acknowledged. A byte carrying any other address is NACKed and changes nothing.
- R3: Command 0xE5 (hold) and command 0xF5 (poll) are acknowledged, and each raises the conversion start for exactly one clock. Any other command byte is NACKed and starts nothing.
- R4: In hold mode, a read address that arrives while the conversion is running is acknowledged. The target then holds SCL low until the done strobe, with no time limit of its own.
- R5: At the end of a stretch, the target drives SDA with the result MSB (pulled low for 0, released for 1) at least one clock before it releases SCL.
- R6: In poll mode, the command write may end with a STOP and other traffic may follow. Each read address before the done strobe is NACKed. The first one after it is acknowledged, and the data follows without stretching.
- R7: A read address received while no conversion is pending is NACKed.
- R8: The result goes out as two bytes, high byte first and MSB first within each byte. A controller ACK after the first byte continues the transfer. After the second byte's acknowledge bit, the target releases SDA and goes idle.
- R9: A START or STOP at any point aborts the transfer and releases SDA. A result not yet fully read stays pending and can be read later in full.
- R10: Once both result bytes have been clocked out, the result is no longer pending, and a further read address is NACKed.
- R11: Apart from aborts on START or STOP, the target changes its SDA drive only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| conv_start | output | 1 | One-clock request to start a conversion |
| conv_done | input | 1 | One-clock strobe: result is valid |
| conv_result | input | 16 | Conversion result, sampled on conv_done |

## Verification
The assertions check the following on every cycle:
- the start pulse lasts a single clock and follows only a known command;
- a stretch ends only once the result is ready, with the MSB already set up and stable on SDA;
- the read-address decision refuses early polls and reads with nothing pending;
- SDA moves only while SCL is low.

Other behaviours can only be shown through the bench's bus scenarios:
- the values of the returned bytes;
- that a stretch really lasts as long as a slow conversion;
- that foreign-address traffic between command and read is harmless;
- that an interrupted read still leaves the result pending;
- that a completed read clears it.

// File: rtl/i2c_meas_pkg.sv
package i2c_meas_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AWAIT, ST_AHOLD, ST_CMD, ST_CWAIT, ST_CHOLD,
    ST_STRETCH, ST_REL, ST_TX, ST_TACK, ST_TNEXT
  } tgt_state_t;

  localparam logic [7:0] CMD_MEAS_HOLD = 8'hE5;
  localparam logic [7:0] CMD_MEAS_POLL = 8'hF5;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == CMD_MEAS_HOLD) || (c == CMD_MEAS_POLL);
  endfunction

  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] a);
    return b[7:1] == a;
  endfunction

  // read address accepted: something pending and either ready or stretchable
  function automatic logic read_accept(input logic pend, input logic rdy, input logic hold);
    return pend && (rdy || hold);
  endfunction

endpackage

// File: rtl/i2c_meas_sync.sv
module i2c_meas_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], d[i]};
    end
    assign q[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2c_meas_cond.sv
module i2c_meas_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic evt_start,
  output logic evt_stop
);
  logic scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
  assign evt_start = scl_s && scl_q && sda_q && !sda_s;
  assign evt_stop  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/i2c_meas_track.sv
module i2c_meas_track #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             accept_hold,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             readout_done,
  output logic             pending,
  output logic             ready,
  output logic             hold_mode,
  output logic [RES_W-1:0] result_q,
  output logic             res_msb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      ready     <= 1'b0;
      hold_mode <= 1'b0;
      result_q  <= '0;
    end else if (accept) begin
      pending   <= 1'b1;
      ready     <= 1'b0;
      hold_mode <= accept_hold;
    end else if (readout_done) begin
      pending <= 1'b0;
      ready   <= 1'b0;
    end else if (conv_done && pending && !ready) begin
      ready    <= 1'b1;
      result_q <= conv_result;
    end
  end
  assign res_msb = result_q[RES_W-1];
endmodule

// File: rtl/i2c_meas_target.sv
module i2c_meas_target
  import i2c_meas_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h40,
  parameter int         RES_W       = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);
  localparam int NBYTES = RES_W / 8;
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(NBYTES - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, evt_start, evt_stop;
  logic pending, ready, hold_mode, res_msb;
  logic [RES_W-1:0] result_q;

  tgt_state_t        st;
  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic              rw;
  logic [RES_W-1:0]  tx_sh;
  logic [BIDX_W-1:0] byte_idx;

  // named events for the checker
  logic ack_dec, rd_addr_hit, accept, readout_done, evt_cond;

  i2c_meas_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2c_meas_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .evt_start(evt_start), .evt_stop(evt_stop)
  );

  i2c_meas_track #(.RES_W(RES_W)) u_track (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .accept_hold(sh == CMD_MEAS_HOLD),
    .conv_done(conv_done), .conv_result(conv_result),
    .readout_done(readout_done), .pending(pending), .ready(ready),
    .hold_mode(hold_mode), .result_q(result_q), .res_msb(res_msb)
  );

  assign evt_cond     = evt_start || evt_stop;
  assign ack_dec      = addr_match(sh, TGT_ADDR) &&
                        (!sh[0] || read_accept(pending, ready, hold_mode));
  assign rd_addr_hit  = (st == ST_AWAIT) && scl_fall && addr_match(sh, TGT_ADDR) && sh[0];
  assign accept       = (st == ST_CWAIT) && scl_fall && cmd_known(sh) && !evt_cond;
  assign readout_done = (st == ST_TACK) && scl_rise && (byte_idx == LAST_BYTE);
  assign conv_start   = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      tx_sh    <= '0;
      byte_idx <= '0;
    end else if (evt_start) begin
      st  <= ST_ADDR;
      cnt <= '0;
    end else if (evt_stop) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_ADDR, ST_CMD: if (scl_rise) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) st <= (st == ST_ADDR) ? ST_AWAIT : ST_CWAIT;
        end
        ST_AWAIT: if (scl_fall) begin
          rw <= sh[0];
          st <= ack_dec ? ST_AHOLD : ST_IDLE;
        end
        ST_AHOLD: if (scl_fall) begin
          cnt      <= '0;
          byte_idx <= '0;
          if (!rw) st <= ST_CMD;
          else if (ready) begin
            tx_sh <= result_q;
            st    <= ST_TX;
          end else st <= ST_STRETCH;
        end
        ST_CWAIT: if (scl_fall) st <= cmd_known(sh) ? ST_CHOLD : ST_IDLE;
        ST_CHOLD: if (scl_fall) st <= ST_IDLE;
        ST_STRETCH: if (ready) begin
          tx_sh <= result_q;
          st    <= ST_REL;
        end
        ST_REL: st <= ST_TX;
        ST_TX: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall && cnt == 4'd8) st <= ST_TACK;
          else if (scl_fall) tx_sh <= tx_sh << 1;
        end
        ST_TACK: if (scl_rise) begin
          st <= (!sda_s && byte_idx != LAST_BYTE) ? ST_TNEXT : ST_IDLE;
        end
        ST_TNEXT: if (scl_fall) begin
          tx_sh    <= tx_sh << 1;
          cnt      <= '0;
          byte_idx <= byte_idx + 1'b1;
          st       <= ST_TX;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign scl_drive_low = (st == ST_STRETCH) || (st == ST_REL);
  assign sda_drive_low = (st == ST_AHOLD) || (st == ST_CHOLD) ||
                         (((st == ST_TX) || (st == ST_REL)) && !tx_sh[RES_W-1]);

endmodule

// File: rtl/i2c_meas_target_chk.sv
module i2c_meas_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       evt_cond,
  input logic       sda_drive_low,
  input logic       scl_drive_low,
  input logic       conv_start,
  input logic [7:0] cmd_byte,
  input logic       rd_addr_hit,
  input logic       ack_dec,
  input logic       pending,
  input logic       ready,
  input logic       hold_mode,
  input logic       res_msb
);
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_start_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (cmd_byte == 8'hE5 || cmd_byte == 8'hF5));

  p_stretch_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> $past(ready));

  p_msb_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> ($stable(sda_drive_low) && (sda_drive_low == !res_msb)));

  p_poll_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_hit && !hold_mode && !ready) |-> !ack_dec);

  p_idle_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_hit && !pending) |-> !ack_dec);

  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_drive_low) && !$past(evt_cond)) |-> !$past(scl_s));
endmodule

bind i2c_meas_target i2c_meas_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .evt_cond(evt_cond),
  .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
  .conv_start(conv_start), .cmd_byte(sh), .rd_addr_hit(rd_addr_hit),
  .ack_dec(ack_dec), .pending(pending), .ready(ready),
  .hold_mode(hold_mode), .res_msb(res_msb)
);

// File: tb/i2c_meas_target_tb.sv
module i2c_meas_target_tb;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_drive_low, sda_drive_low, conv_start;
  logic conv_done = 1'b0;
  logic [15:0] conv_result;
  wire scl_line = !(m_scl_low || scl_drive_low);
  wire sda_line = !(m_sda_low || sda_drive_low);

  i2c_meas_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result)
  );

  int n_checks = 0, n_fail = 0;
  int starts = 0, eng_cnt = 0, conv_delay = 100;
  logic [15:0] res_val = 16'h0000;
  int last_stretch = 0;
  logic first_sda = 1'b1;
  int r11_viol = 0;
  logic [15:0] exp_q[$];
  logic [15:0] got_q[$];
  assign conv_result = res_val;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // conversion engine model
  initial forever begin
    @(negedge clk);
    conv_done = 1'b0;
    if (conv_start) begin
      starts++;
      eng_cnt = conv_delay;
    end else if (eng_cnt == 1) begin
      conv_done = 1'b1;
      eng_cnt = 0;
    end else if (eng_cnt > 1) eng_cnt--;
  end

  // monitor: scoreboard compare and SDA-change watch
  initial begin
    logic prev_sda = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_drive_low != prev_sda && scl_line) r11_viol++;
      prev_sda = sda_drive_low;
      while (got_q.size() > 0) begin
        logic [15:0] g, e;
        g = got_q.pop_front();
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected word", g, 0);
        else begin
          e = exp_q.pop_front();
          check(g == e, "R8 result word", g, e);
        end
      end
    end
  end

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic scl_release();
    int n = 0;
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) begin
      n++;
      @(negedge clk);
    end
    last_stretch = n;
    first_sda = sda_line;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; half_wait();
    scl_release(); half_wait();
    m_sda_low = 1'b1; half_wait();
    m_scl_low = 1'b1; half_wait();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; half_wait();
    scl_release(); half_wait();
    m_sda_low = 1'b0; half_wait();
  endtask

  task automatic wr_bit(input logic b);
    m_sda_low = !b; half_wait();
    scl_release(); half_wait();
    m_scl_low = 1'b1;
  endtask

  task automatic rd_bit(output logic b);
    m_sda_low = 1'b0; half_wait();
    scl_release(); half_wait();
    b = sda_line;
    m_scl_low = 1'b1;
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(a);
    acked = !a;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rd_bit(v[i]);
    wr_bit(!give_ack);
  endtask

  task automatic rd_word(output int stretch, output logic msb_seen);
    logic [7:0] hi, lo;
    logic b;
    rd_bit(b);
    stretch = last_stretch;
    msb_seen = first_sda;
    hi[7] = b;
    for (int i = 6; i >= 0; i--) rd_bit(hi[i]);
    wr_bit(1'b0);
    rd_byte(1'b0, lo);
    got_q.push_back({hi, lo});
  endtask

  task automatic expect_word(input logic [15:0] v);
    exp_q.push_back(v);
  endtask

  initial begin
    int watchdog = 0;
    forever begin
      @(negedge clk);
      watchdog++;
      if (watchdog == 150000) begin
        check(1'b0, "watchdog", watchdog, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    logic ack;
    logic msb;
    int st;
    logic [7:0] byt;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!scl_drive_low && !sda_drive_low, "R1 drives released", {scl_drive_low, sda_drive_low}, 0);
    check(starts == 0, "R1 no conversion start", starts, 0);

    // R2 foreign address
    bus_start(); wr_byte(8'h42, ack); bus_stop();
    check(!ack, "R2 foreign address NACK", ack, 0);

    // R3 unknown command
    bus_start(); wr_byte(8'h80, ack);
    check(ack, "R2 own write address ACK", ack, 1);
    wr_byte(8'h12, ack); bus_stop();
    check(!ack, "R3 unknown command NACK", ack, 0);
    check(starts == 0, "R3 unknown command no start", starts, 0);

    // R7 nothing pending
    bus_start(); wr_byte(8'h81, ack); bus_stop();
    check(!ack, "R7 read with nothing pending NACK", ack, 0);

    // R4/R5 hold mode, MSB 0, long conversion
    res_val = 16'h1234; conv_delay = 3000;
    bus_start(); wr_byte(8'h80, ack); wr_byte(8'hE5, ack);
    check(ack, "R3 hold command ACK", ack, 1);
    check(starts == 1, "R3 hold command one start", starts, 1);
    bus_start(); wr_byte(8'h81, ack);
    check(ack, "R4 hold read address ACK while busy", ack, 1);
    expect_word(16'h1234);
    rd_word(st, msb);
    bus_stop();
    check(st > 2000, "R4 SCL stretched over conversion", st, 2000);
    check(msb == 1'b0, "R5 MSB 0 on SDA at stretch end", msb, 0);
    check(!sda_drive_low, "R8 SDA released after readout", sda_drive_low, 0);
    // R10 result consumed
    bus_start(); wr_byte(8'h81, ack); bus_stop();
    check(!ack, "R10 read after full readout NACK", ack, 0);

    // R5 MSB 1
    res_val = 16'h9ABC; conv_delay = 900;
    bus_start(); wr_byte(8'h80, ack); wr_byte(8'hE5, ack);
    bus_start(); wr_byte(8'h81, ack);
    expect_word(16'h9ABC);
    rd_word(st, msb);
    bus_stop();
    check(msb == 1'b1, "R5 MSB 1 released at stretch end", msb, 1);

    // R6 poll mode with STOP and foreign traffic
    res_val = 16'h5A3C; conv_delay = 4000;
    bus_start(); wr_byte(8'h80, ack); wr_byte(8'hF5, ack); bus_stop();
    check(ack, "R3 poll command ACK", ack, 1);
    bus_start(); wr_byte(8'h66, ack); wr_byte(8'h00, ack); bus_stop();
    bus_start(); wr_byte(8'h81, ack); bus_stop();
    check(!ack, "R6 early poll NACK", ack, 0);
    repeat (4500) @(negedge clk);
    bus_start(); wr_byte(8'h81, ack);
    check(ack, "R6 poll after done ACK", ack, 1);
    expect_word(16'h5A3C);
    rd_word(st, msb);
    bus_stop();
    check(st < 4, "R6 no stretch in poll mode", st, 0);

    // R9 abort by repeated START mid-byte keeps result
    res_val = 16'h0F0F; conv_delay = 200;
    bus_start(); wr_byte(8'h80, ack); wr_byte(8'hF5, ack); bus_stop();
    repeat (400) @(negedge clk);
    bus_start(); wr_byte(8'h81, ack);
    rd_byte(1'b1, byt);
    check(byt == 8'h0F, "R8 high byte first", byt, 8'h0F);
    for (int i = 0; i < 4; i++) rd_bit(msb);
    bus_start();
    check(!sda_drive_low, "R9 SDA released on START", sda_drive_low, 0);
    wr_byte(8'h81, ack);
    check(ack, "R9 result still pending after abort", ack, 1);
    expect_word(16'h0F0F);
    rd_word(st, msb);
    bus_stop();

    repeat (50) @(negedge clk);
    check(exp_q.size() == 0 && got_q.size() == 0, "R8 all words compared", exp_q.size(), 0);
    check(r11_viol == 0, "R11 SDA changes only with SCL low", r11_viol, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule